// File: doc/BRIEF.md
# Floating-Point Add/Subtract Path Selector

This block sits in front of an extended-precision adder. For two finite, nonzero operands it decides how the sum or difference is formed, but it does not do the significand arithmetic. Each operand is given as a sign bit, a 16-bit biased exponent and a 64-bit significand that arrives as an upper and a lower 32-bit word. The control inputs are an opcode (add or subtract), a reverse flag that swaps the roles of the operands, and a 2-bit rounding-control field.

The block outputs four things. The first says whether the downstream datapath adds or subtracts magnitudes. The second says whether the operands are swapped, so that the larger magnitude becomes the minuend. The third is the sign of the result. The fourth flags an exactly cancelling result; for that case the sign output holds the sign of the zero, which the rounding mode picks. The decision is formed combinationally, registered, and marked by a valid signal one clock after the request.

Top module: `fpas_path_sel`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `out_valid`, `mag_sub`, `swap`, `res_sign` and `zero_res` are all 0 after that edge.
- R2: `out_valid` equals `in_valid` of the previous clock. The other outputs describe the inputs presented in that previous clock.
- R3: When `rev` is 1, both operand signs are inverted before any classification. A subtract then yields B − A.
- R4: An addition (`op_sub`=0) whose effective signs are equal gives `mag_sub`=0, `swap`=0 and `zero_res`=0, with `res_sign` equal to A's effective sign.
- R5: An addition whose effective signs differ subtracts magnitudes (`mag_sub`=1). Magnitudes compare as unsigned values: exponent first, then the upper significand word, then the lower word.
- R6: When magnitudes are subtracted and are unequal, `swap`=1 exactly when |B| > |A|. `res_sign` is the effective sign of the larger operand, where B's effective sign in a subtraction is its sign after inversion.
- R7: A subtraction (`op_sub`=1) classifies on the effective sign pair. Positive−positive and negative−negative give `mag_sub`=1. Positive−negative gives `mag_sub`=0 with `res_sign`=0. Negative−positive gives `mag_sub`=0 with `res_sign`=1. `swap` is 0 in all add cases.
- R8: A same-sign subtraction with |A| < |B| gives `swap`=1, and `res_sign` is the inverse of A's effective sign.
- R9: When magnitudes are subtracted and are exactly equal, `zero_res`=1, `mag_sub`=1 and `swap`=0. `res_sign` is 1 only when `rc`=01 (toward negative). The `rc` encoding is 00 nearest, 01 toward negative, 10 toward positive, 11 toward zero.
- R10: When the exponents and upper words match, the lower significand word alone decides the order, also when it differs only in its least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_sub | input | 1 | 0 add, 1 subtract |
| rev | input | 1 | Invert both operand signs (reversed subtract) |
| rc | input | 2 | Rounding control: 00 nearest, 01 down, 10 up, 11 toward zero |
| a_sign | input | 1 | Operand A sign |
| a_exp | input | 16 | Operand A biased exponent |
| a_sig_hi | input | 32 | Operand A significand, upper word |
| a_sig_lo | input | 32 | Operand A significand, lower word |
| b_sign | input | 1 | Operand B sign |
| b_exp | input | 16 | Operand B biased exponent |
| b_sig_hi | input | 32 | Operand B significand, upper word |
| b_sig_lo | input | 32 | Operand B significand, lower word |
| out_valid | output | 1 | Decision valid |
| mag_sub | output | 1 | 1 subtract magnitudes, 0 add |
| swap | output | 1 | Exchange operands so B is the minuend |
| res_sign | output | 1 | Result sign, or sign of the exact zero |
| zero_res | output | 1 | Exact cancellation: result is zero |

## Verification
The hardest cases to reach are the ones where the exponents and upper words match, so the lower word alone decides, together with exact cancellation under each rounding mode. Random operands almost never produce them. The bench therefore builds these operand pairs on purpose, with lower words one LSB apart in both directions and with an upper word that disagrees with the lower one. It runs them under every opcode, reverse-flag and sign combination, and repeats equal magnitudes under all four `rc` codes.

// File: rtl/fpas_pkg.sv
// Package: shared types for the add/subtract path selector.
// Assumes a 2-bit rounding-control field with the encoding listed below.
package fpas_pkg;

    // Rounding control codes; only RND_DOWN alters the sign of an exact zero.
    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_DOWN    = 2'b01,
        RND_UP      = 2'b10,
        RND_TRUNC   = 2'b11
    } rnd_mode_e;

    // Result of the magnitude comparison of A against B.
    typedef enum logic [1:0] {
        MAG_EQ    = 2'b00,
        MAG_A_BIG = 2'b01,
        MAG_B_BIG = 2'b10
    } mag_ord_e;

    // Decision handed to the significand datapath.
    typedef struct packed {
        logic mag_sub;
        logic swap;
        logic res_sign;
        logic zero_res;
    } path_dec_t;

endpackage

// File: rtl/fpas_field_cmp.sv
// Module: unsigned comparison of one field of the two operands.
// Assumes both fields are unsigned and of equal width W.
module fpas_field_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] fld_a,
    input  logic [W-1:0] fld_b,
    output logic         a_gt,
    output logic         a_lt
);
    // Flag a strict ordering in either direction.
    always_comb begin
        a_gt = (fld_a > fld_b);
        a_lt = (fld_a < fld_b);
    end
endmodule

// File: rtl/fpas_mag_order.sv
// Module: orders |A| against |B| lexicographically: exponent, then the
// significand words from most to least significant.
// Assumes SIG_W is a whole multiple of WORD_W.
module fpas_mag_order
    import fpas_pkg::*;
#(
    parameter int EXP_W  = 16,
    parameter int WORD_W = 32,
    parameter int SIG_W  = 64
) (
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  logic [SIG_W-1:0] sig_a,
    input  logic [SIG_W-1:0] sig_b,
    output mag_ord_e         ord
);
    localparam int WORDS = SIG_W / WORD_W;

    logic             exp_gt;
    logic             exp_lt;
    logic [WORDS-1:0] word_gt;
    logic [WORDS-1:0] word_lt;

    fpas_field_cmp #(.W(EXP_W)) u_exp_cmp (
        .fld_a (exp_a),
        .fld_b (exp_b),
        .a_gt  (exp_gt),
        .a_lt  (exp_lt)
    );

    // One comparator per significand word; index 0 is the least significant.
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        fpas_field_cmp #(.W(WORD_W)) u_word_cmp (
            .fld_a (sig_a[g*WORD_W +: WORD_W]),
            .fld_b (sig_b[g*WORD_W +: WORD_W]),
            .a_gt  (word_gt[g]),
            .a_lt  (word_lt[g])
        );
    end

    // Priority merge: more significant fields override less significant ones.
    always_comb begin
        ord = MAG_EQ;
        for (int i = 0; i < WORDS; i++) begin
            if (word_gt[i]) ord = MAG_A_BIG;
            else if (word_lt[i]) ord = MAG_B_BIG;
        end
        if (exp_gt) ord = MAG_A_BIG;
        else if (exp_lt) ord = MAG_B_BIG;
    end
endmodule

// File: rtl/fpas_sign_prep.sv
// Module: forms the effective operand signs. The reverse flag inverts both
// signs; a subtract then folds into B's sign so that later stages only see
// an addition of signed magnitudes.
// Assumes signs are 1 for negative.
module fpas_sign_prep (
    input  logic op_sub,
    input  logic rev,
    input  logic a_sign,
    input  logic b_sign,
    output logic eff_a,
    output logic eff_b_add,
    output logic signs_differ
);
    // Apply the reverse flag, then fold the opcode into operand B.
    always_comb begin
        eff_a        = a_sign ^ rev;
        eff_b_add    = b_sign ^ rev ^ op_sub;
        signs_differ = eff_a ^ eff_b_add;
    end
endmodule

// File: rtl/fpas_decide.sv
// Module: combines sign classification, magnitude order and rounding mode
// into the path decision.
// Assumes operands are finite and nonzero; specials are handled elsewhere.
module fpas_decide
    import fpas_pkg::*;
(
    input  logic       eff_a,
    input  logic       eff_b_add,
    input  logic       signs_differ,
    input  mag_ord_e   ord,
    input  logic [1:0] rc,
    output path_dec_t  dec
);
    // Pick add or subtract, operand order and result sign.
    always_comb begin
        dec = '0;
        if (!signs_differ) begin
            dec.res_sign = eff_a;
        end else begin
            dec.mag_sub = 1'b1;
            unique case (ord)
                MAG_A_BIG: dec.res_sign = eff_a;
                MAG_B_BIG: begin
                    dec.swap     = 1'b1;
                    dec.res_sign = eff_b_add;
                end
                default: begin
                    dec.zero_res = 1'b1;
                    dec.res_sign = (rnd_mode_e'(rc) == RND_DOWN);
                end
            endcase
        end
    end
endmodule

// File: rtl/fpas_path_sel.sv
// Module: top of the add/subtract path selector. Registers the decision one
// clock after the request, with a synchronous active-low reset.
// Assumes the caller filters zero, infinite, NaN and denormal operands.
module fpas_path_sel
    import fpas_pkg::*;
#(
    parameter int EXP_W  = 16,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic              rev,
    input  logic [1:0]        rc,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [HALF_W-1:0] a_sig_hi,
    input  logic [HALF_W-1:0] a_sig_lo,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [HALF_W-1:0] b_sig_hi,
    input  logic [HALF_W-1:0] b_sig_lo,
    output logic              out_valid,
    output logic              mag_sub,
    output logic              swap,
    output logic              res_sign,
    output logic              zero_res
);
    localparam int SIG_W = 2 * HALF_W;

    logic      eff_a;
    logic      eff_b_add;
    logic      signs_differ;
    mag_ord_e  ord;
    path_dec_t dec;

    fpas_sign_prep u_sign (
        .op_sub       (op_sub),
        .rev          (rev),
        .a_sign       (a_sign),
        .b_sign       (b_sign),
        .eff_a        (eff_a),
        .eff_b_add    (eff_b_add),
        .signs_differ (signs_differ)
    );

    fpas_mag_order #(
        .EXP_W  (EXP_W),
        .WORD_W (HALF_W),
        .SIG_W  (SIG_W)
    ) u_order (
        .exp_a (a_exp),
        .exp_b (b_exp),
        .sig_a ({a_sig_hi, a_sig_lo}),
        .sig_b ({b_sig_hi, b_sig_lo}),
        .ord   (ord)
    );

    fpas_decide u_decide (
        .eff_a        (eff_a),
        .eff_b_add    (eff_b_add),
        .signs_differ (signs_differ),
        .ord          (ord),
        .rc           (rc),
        .dec          (dec)
    );

    // Output register: capture the decision and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            mag_sub   <= 1'b0;
            swap      <= 1'b0;
            res_sign  <= 1'b0;
            zero_res  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            mag_sub   <= dec.mag_sub;
            swap      <= dec.swap;
            res_sign  <= dec.res_sign;
            zero_res  <= dec.zero_res;
        end
    end
endmodule

// File: rtl/fpas_path_sel_chk.sv
// Module: property checker for fpas_path_sel, bound to every instance.
// Assumes outputs lag the inputs by exactly one clock.
module fpas_path_sel_chk #(
    parameter int EXP_W  = 16,
    parameter int HALF_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              op_sub,
    input logic              rev,
    input logic [1:0]        rc,
    input logic              a_sign,
    input logic [EXP_W-1:0]  a_exp,
    input logic [HALF_W-1:0] a_sig_hi,
    input logic [HALF_W-1:0] a_sig_lo,
    input logic              b_sign,
    input logic [EXP_W-1:0]  b_exp,
    input logic [HALF_W-1:0] b_sig_hi,
    input logic [HALF_W-1:0] b_sig_lo,
    input logic              out_valid,
    input logic              mag_sub,
    input logic              swap,
    input logic              res_sign,
    input logic              zero_res
);
    // R1: reset clears the valid flag and the zero flag.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !zero_res));

    // R2: valid follows the request by one clock.
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R4: same effective signs in an addition add magnitudes.
    a_r4_add_same_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(op_sub) && ($past(a_sign) == $past(b_sign)))
        |-> (!mag_sub && !swap && !zero_res && (res_sign == ($past(a_sign) ^ $past(rev)))));

    // R7: opposite signs in a subtraction add magnitudes, sign from A.
    a_r7_sub_cross_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_sub) && ($past(a_sign) != $past(b_sign)))
        |-> (!mag_sub && !swap && (res_sign == ($past(a_sign) ^ $past(rev)))));

    // R5: a larger exponent on A keeps A as minuend.
    a_r5_exp_a_big: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mag_sub && ($past(a_exp) > $past(b_exp)))
        |-> (!swap && !zero_res));

    // R6: a larger exponent on B swaps the operands.
    a_r6_exp_b_big: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mag_sub && ($past(a_exp) < $past(b_exp)))
        |-> (swap && !zero_res));

    // R6: result sign follows the minuend's effective sign.
    a_r6_minuend_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mag_sub && !zero_res)
        |-> (res_sign == (swap ? ($past(b_sign) ^ $past(rev) ^ $past(op_sub))
                               : ($past(a_sign) ^ $past(rev)))));

    // R9: an exact zero is a subtraction without swap, signed by rounding mode.
    a_r9_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zero_res)
        |-> (mag_sub && !swap && (res_sign == ($past(rc) == 2'b01))));

    // R10: with exponent and upper word equal, a larger lower word on A wins.
    a_r10_lo_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mag_sub && $past(a_exp == b_exp && a_sig_hi == b_sig_hi
                                       && a_sig_lo > b_sig_lo))
        |-> (!swap && !zero_res));
endmodule

bind fpas_path_sel fpas_path_sel_chk #(
    .EXP_W  (EXP_W),
    .HALF_W (HALF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sub    (op_sub),
    .rev       (rev),
    .rc        (rc),
    .a_sign    (a_sign),
    .a_exp     (a_exp),
    .a_sig_hi  (a_sig_hi),
    .a_sig_lo  (a_sig_lo),
    .b_sign    (b_sign),
    .b_exp     (b_exp),
    .b_sig_hi  (b_sig_hi),
    .b_sig_lo  (b_sig_lo),
    .out_valid (out_valid),
    .mag_sub   (mag_sub),
    .swap      (swap),
    .res_sign  (res_sign),
    .zero_res  (zero_res)
);

// File: tb/fpas_path_sel_tb_top.sv
// Directed bench for fpas_path_sel. Each scenario task drives requests at
// the falling edge and checks the registered outputs one falling edge later.
module fpas_path_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic        rev = 1'b0;
    logic [1:0]  rc = 2'b00;
    logic        a_sign = 1'b0;
    logic [15:0] a_exp = '0;
    logic [31:0] a_sig_hi = '0;
    logic [31:0] a_sig_lo = '0;
    logic        b_sign = 1'b0;
    logic [15:0] b_exp = '0;
    logic [31:0] b_sig_hi = '0;
    logic [31:0] b_sig_lo = '0;
    logic        out_valid, mag_sub, swap, res_sign, zero_res;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fpas_path_sel dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .op_sub (op_sub), .rev (rev), .rc (rc),
        .a_sign (a_sign), .a_exp (a_exp), .a_sig_hi (a_sig_hi), .a_sig_lo (a_sig_lo),
        .b_sign (b_sign), .b_exp (b_exp), .b_sig_hi (b_sig_hi), .b_sig_lo (b_sig_lo),
        .out_valid (out_valid), .mag_sub (mag_sub), .swap (swap),
        .res_sign (res_sign), .zero_res (zero_res)
    );

    // Reference decision taken straight from the requirements; returns
    // {mag_sub, swap, res_sign, zero_res}.
    function automatic logic [3:0] ref_dec(input logic o_sub, input logic o_rev,
                                           input logic [1:0] o_rc,
                                           input logic sa, input logic [79:0] ma,
                                           input logic sb, input logic [79:0] mb);
        logic ea, eb;
        ea = sa ^ o_rev;
        eb = sb ^ o_rev;
        if (!o_sub) begin
            if (ea == eb)     return {1'b0, 1'b0, ea, 1'b0};
            else if (ma > mb) return {1'b1, 1'b0, ea, 1'b0};
            else if (ma < mb) return {1'b1, 1'b1, eb, 1'b0};
            else              return {1'b1, 1'b0, o_rc == 2'b01, 1'b1};
        end
        case ({ea, eb})
            2'b01:   return {1'b0, 1'b0, 1'b0, 1'b0};
            2'b10:   return {1'b0, 1'b0, 1'b1, 1'b0};
            default: begin
                if (ma > mb)      return {1'b1, 1'b0, ea, 1'b0};
                else if (ma < mb) return {1'b1, 1'b1, ~ea, 1'b0};
                else              return {1'b1, 1'b0, o_rc == 2'b01, 1'b1};
            end
        endcase
    endfunction

    // Drive one request, wait for its registered result, compare.
    task automatic run_case(input string tag, input logic o_sub, input logic o_rev,
                            input logic [1:0] o_rc,
                            input logic sa, input logic [15:0] ea,
                            input logic [31:0] ha, input logic [31:0] la,
                            input logic sb, input logic [15:0] eb,
                            input logic [31:0] hb, input logic [31:0] lb);
        logic [3:0] exp_d;
        logic [4:0] got;
        @(negedge clk);
        in_valid = 1'b1; op_sub = o_sub; rev = o_rev; rc = o_rc;
        a_sign = sa; a_exp = ea; a_sig_hi = ha; a_sig_lo = la;
        b_sign = sb; b_exp = eb; b_sig_hi = hb; b_sig_lo = lb;
        exp_d = ref_dec(o_sub, o_rev, o_rc, sa, {ea, ha, la}, sb, {eb, hb, lb});
        @(negedge clk);
        in_valid = 1'b0;
        got = {out_valid, mag_sub, swap, res_sign, zero_res};
        n_chk++;
        if (got != {1'b1, exp_d}) begin
            n_bad++;
            $display("FAIL %s: {valid,mag_sub,swap,sign,zero} actual=%b expected=%b",
                     tag, got, {1'b1, exp_d});
        end
    endtask

    // R1: reset holds the outputs clear even with a request pending.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; op_sub = 1'b0; rev = 1'b0; rc = 2'b01;
        a_sign = 1'b1; b_sign = 1'b0; a_exp = 16'h3fff; b_exp = 16'h3fff;
        a_sig_hi = 32'h8000_0000; b_sig_hi = 32'h8000_0000; a_sig_lo = 0; b_sig_lo = 0;
        repeat (2) @(negedge clk);
        n_chk++;
        if ({out_valid, mag_sub, swap, res_sign, zero_res} != 5'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual=%b expected=00000",
                     {out_valid, mag_sub, swap, res_sign, zero_res});
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    // R2: valid tracks the request with one clock of latency.
    task automatic t_latency();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 idle valid: actual=%b expected=0", out_valid);
        end
        run_case("R2 valid after request", 1'b0, 1'b0, 2'b00,
                 1'b0, 16'h4000, 32'h8000_0000, 32'h0, 1'b0, 16'h3fff, 32'h8000_0000, 32'h0);
    endtask

    // R4: additions with matching signs.
    task automatic t_add_same();
        for (int s = 0; s < 2; s++) begin
            run_case("R4 add same sign A big", 1'b0, 1'b0, 2'b00,
                     s[0], 16'h4001, 32'hc000_0000, 32'h1, s[0], 16'h3ffe, 32'h8000_0000, 32'h0);
            run_case("R4 add same sign B big", 1'b0, 1'b0, 2'b01,
                     s[0], 16'h3ffe, 32'h8000_0000, 32'h0, s[0], 16'h4001, 32'hc000_0000, 32'h1);
        end
    endtask

    // R5/R6: additions with opposite signs, ordering decided by the exponent
    // even when the significands point the other way.
    task automatic t_add_diff();
        run_case("R5 add diff exp A big", 1'b0, 1'b0, 2'b00,
                 1'b1, 16'h4002, 32'h8000_0000, 32'h0, 1'b0, 16'h4001, 32'hffff_ffff, 32'hffff_ffff);
        run_case("R6 add diff exp B big", 1'b0, 1'b0, 2'b00,
                 1'b1, 16'h4001, 32'hffff_ffff, 32'hffff_ffff, 1'b0, 16'h4002, 32'h8000_0000, 32'h0);
        run_case("R5 add diff upper word", 1'b0, 1'b0, 2'b10,
                 1'b0, 16'h4000, 32'h8000_0001, 32'h0, 1'b1, 16'h4000, 32'h8000_0000, 32'hffff_ffff);
        run_case("R6 add diff upper word B big", 1'b0, 1'b0, 2'b10,
                 1'b0, 16'h4000, 32'h8000_0000, 32'hffff_ffff, 1'b1, 16'h4000, 32'h8000_0001, 32'h0);
    endtask

    // R7/R8: every subtraction sign pair with both magnitude orders.
    task automatic t_sub_pairs();
        for (int p = 0; p < 4; p++) begin
            run_case("R7 sub pair A big", 1'b1, 1'b0, 2'b00,
                     p[1], 16'h4005, 32'h9000_0000, 32'h0, p[0], 16'h4003, 32'h8000_0000, 32'h0);
            run_case("R8 sub pair B big", 1'b1, 1'b0, 2'b00,
                     p[1], 16'h4003, 32'h8000_0000, 32'h0, p[0], 16'h4005, 32'h9000_0000, 32'h0);
        end
    endtask

    // R3: the reverse flag inverts both signs for add and subtract.
    task automatic t_reverse();
        for (int p = 0; p < 4; p++) begin
            run_case("R3 rev sub A big", 1'b1, 1'b1, 2'b00,
                     p[1], 16'h4010, 32'h8000_0000, 32'h5, p[0], 16'h400f, 32'h8000_0000, 32'h5);
            run_case("R3 rev sub B big", 1'b1, 1'b1, 2'b00,
                     p[1], 16'h400f, 32'h8000_0000, 32'h5, p[0], 16'h4010, 32'h8000_0000, 32'h5);
            run_case("R3 rev add", 1'b0, 1'b1, 2'b00,
                     p[1], 16'h400f, 32'ha000_0000, 32'h0, p[0], 16'h400f, 32'h9000_0000, 32'h0);
        end
    endtask

    // R9: exact cancellation under every rounding code and operation.
    task automatic t_zero();
        for (int m = 0; m < 4; m++) begin
            run_case("R9 zero sub", 1'b1, 1'b0, m[1:0],
                     1'b1, 16'h1234, 32'h8765_4321, 32'h0fed_cba9, 1'b1, 16'h1234, 32'h8765_4321, 32'h0fed_cba9);
            run_case("R9 zero add", 1'b0, 1'b0, m[1:0],
                     1'b0, 16'h1234, 32'h8765_4321, 32'h0fed_cba9, 1'b1, 16'h1234, 32'h8765_4321, 32'h0fed_cba9);
            run_case("R9 zero rev sub", 1'b1, 1'b1, m[1:0],
                     1'b0, 16'h7ffe, 32'hffff_ffff, 32'hffff_ffff, 1'b0, 16'h7ffe, 32'hffff_ffff, 32'hffff_ffff);
        end
    endtask

    // R10/R6: lower word one LSB apart, under every control and sign combination.
    task automatic t_lo_word();
        for (int c = 0; c < 16; c++) begin
            run_case("R10 lower word A big", c[3], c[2], 2'b00,
                     c[1], 16'h3fff, 32'hdead_beef, 32'h0000_1001, c[0], 16'h3fff, 32'hdead_beef, 32'h0000_1000);
            run_case("R10 lower word B big", c[3], c[2], 2'b11,
                     c[1], 16'h3fff, 32'hdead_beef, 32'h8000_0000, c[0], 16'h3fff, 32'hdead_beef, 32'h8000_0001);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_add_same();
        t_add_diff();
        t_sub_pairs();
        t_reverse();
        t_zero();
        t_lo_word();
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule